// File: doc/BRIEF.md
# Paced Receive Byte Acceptor

This block sits between a byte stream that arrives over a valid/ready handshake and the receive data register of a serial port. It takes at most one byte per frame time. Once a byte has been taken, the ready output stays low until a pacing counter, loaded with the current frame duration in clock cycles, has run down to zero. This is how the block models the wire time of one character. Ready is also held low while receive is disabled.

A taken byte either lands in the data register, or it is dropped when the register still holds an unread byte. A landed byte sets the receive-full flag and can pulse a receive interrupt. A dropped byte sets the overrun flag and can raise a level error interrupt. A separate break input sets a framing-error flag, and it raises the same error interrupt.

The register controller beside the block supplies two strobes. One strobe marks the data register as read. The other clears the error flags. Dropping the interrupt enable also removes the error request.

Top module: `paced_rx_acceptor`

## Requirements
- R1: `in_ready` is high only while `rx_en` is high and the pacing counter is zero. Right after reset the counter is zero, so with `rx_en` high the first byte is taken at once.
- R2: Every taken byte (`in_valid` and `in_ready` high at a rising edge), whether stored or dropped, loads the counter with `frame_cycles`. `in_ready` is then low for exactly `frame_cycles` cycles after that edge. A `frame_cycles` of zero imposes no gap.
- R3: A taken byte that is not an overrun appears on `rx_data`, and `full_flag` is set, in the cycle after the accepting edge.
- R4: When `full_flag` is set and `full_clr` is low at the accepting edge, the byte is discarded, `rx_data` keeps its value and `ovr_flag` is set.
- R5: A stored byte makes `rxi_pulse` high for the one following cycle when `rx_irq_en` was high. A stored byte makes no pulse when `rx_irq_en` was low.
- R6: An overrun or a break with `rx_irq_en` high sets `eri_level`. The level stays high until `err_clr` is seen or `rx_irq_en` is low, and it is low in the cycle after either.
- R7: `brk_evt` sets `frm_flag` in the next cycle, whatever the state of `rx_en`.
- R8: `full_clr` clears `full_flag`. If it arrives in the same cycle as a taken byte, the byte is stored rather than dropped, and `full_flag` stays set.
- R9: `err_clr` clears `ovr_flag` and `frm_flag`. A new overrun or break in the same cycle wins over the clear.
- R10: After reset `full_flag`, `ovr_flag`, `frm_flag`, `rxi_pulse` and `eri_level` are low, and `rx_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| rx_irq_en | input | 1 | Receive/error interrupt enable |
| frame_cycles | input | TIMER_W | Frame duration in clock cycles |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | DATA_W | Incoming byte |
| in_ready | output | 1 | Block can take a byte |
| brk_evt | input | 1 | Break detected on the line (one-cycle strobe) |
| full_clr | input | 1 | Data register read strobe |
| err_clr | input | 1 | Error flags clear strobe |
| rx_data | output | DATA_W | Receive data register |
| full_flag | output | 1 | Receive-full flag |
| ovr_flag | output | 1 | Overrun flag |
| frm_flag | output | 1 | Framing-error flag |
| rxi_pulse | output | 1 | One-cycle receive interrupt |
| eri_level | output | 1 | Level error interrupt |

## Verification
A pacing counter that loads or counts wrongly shows up on `in_ready`. The handshake either reopens before `frame_cycles` cycles have passed, or it stays closed for too long. A full flag that holds a wrong value reveals itself at the next byte. That byte either overwrites `rx_data` when it should set `ovr_flag`, or it is dropped when a clear arrived in the same cycle. A stuck or lost error level appears on `eri_level` one cycle after the break, clear or enable change that should have moved it.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
   // Outcome of a handshake cycle at the data register
   typedef enum logic [1:0] {
      ARR_NONE  = 2'd0,
      ARR_STORE = 2'd1,
      ARR_DROP  = 2'd2
   } arr_kind_e;
endpackage

// File: rtl/rxa_pace_timer.sv
module rxa_pace_timer #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [TIMER_W-1:0] load_val,
   output logic               expired
);
   localparam logic [TIMER_W-1:0] ZERO = '0;
   localparam logic [TIMER_W-1:0] ONE  = {{(TIMER_W-1){1'b0}}, 1'b1};

   logic [TIMER_W-1:0] cnt_q;

   // Reset leaves the counter at zero: the first byte is not held back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= ZERO;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != ZERO)
         cnt_q <= cnt_q - ONE;
   end

   assign expired = (cnt_q == ZERO);
endmodule

// File: rtl/rxa_capture.sv
module rxa_capture
   import rxa_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] in_data,
   input  logic              full_clr,
   output arr_kind_e         kind,
   output logic [DATA_W-1:0] rx_data,
   output logic              full_flag
);
   logic full_q;
   logic still_full;

   // A read strobe in the same cycle frees the register for the new byte
   assign still_full = full_q & ~full_clr;

   always_comb begin
      if (!accept)
         kind = ARR_NONE;
      else if (still_full)
         kind = ARR_DROP;
      else
         kind = ARR_STORE;
   end

   // The set from a store wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         full_q <= 1'b0;
      else
         full_q <= (kind == ARR_STORE) | still_full;
   end

   generate
      if (RESET_DATA) begin : g_data_rst
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               data_q <= '0;
            else if (kind == ARR_STORE)
               data_q <= in_data;
         end
         assign rx_data = data_q;
      end else begin : g_data_norst
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (kind == ARR_STORE)
               data_q <= in_data;
         end
         assign rx_data = data_q;
      end
   endgenerate

   assign full_flag = full_q;
endmodule

// File: rtl/rxa_status_irq.sv
module rxa_status_irq
   import rxa_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  arr_kind_e kind,
   input  logic      brk_evt,
   input  logic      err_clr,
   input  logic      irq_en,
   output logic      ovr_flag,
   output logic      frm_flag,
   output logic      rxi_pulse,
   output logic      eri_level
);
   logic ovr_q, frm_q, rxi_q, eri_q;
   logic ovr_set, err_set;

   assign ovr_set = (kind == ARR_DROP);
   assign err_set = ovr_set | brk_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         frm_q <= 1'b0;
         rxi_q <= 1'b0;
         eri_q <= 1'b0;
      end else begin
         ovr_q <= ovr_set | (ovr_q & ~err_clr);
         frm_q <= brk_evt | (frm_q & ~err_clr);
         rxi_q <= (kind == ARR_STORE) & irq_en;
         // Level held until a clear or until the enable drops
         eri_q <= irq_en & (err_set | (eri_q & ~err_clr));
      end
   end

   assign ovr_flag  = ovr_q;
   assign frm_flag  = frm_q;
   assign rxi_pulse = rxi_q;
   assign eri_level = eri_q;
endmodule

// File: rtl/paced_rx_acceptor.sv
module paced_rx_acceptor
   import rxa_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int TIMER_W    = 16,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_en,
   input  logic               rx_irq_en,
   input  logic [TIMER_W-1:0] frame_cycles,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_data,
   output logic               in_ready,
   input  logic               brk_evt,
   input  logic               full_clr,
   input  logic               err_clr,
   output logic [DATA_W-1:0]  rx_data,
   output logic               full_flag,
   output logic               ovr_flag,
   output logic               frm_flag,
   output logic               rxi_pulse,
   output logic               eri_level
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("paced_rx_acceptor: DATA_W must be at least 1");
      end
      if (TIMER_W < 1 || TIMER_W > 32) begin : g_bad_timer_w
         $error("paced_rx_acceptor: TIMER_W must lie in 1..32");
      end
   endgenerate

   logic      pace_done;
   logic      accept;
   arr_kind_e kind;

   assign in_ready = rx_en & pace_done;
   assign accept   = in_valid & in_ready;

   rxa_pace_timer #(.TIMER_W(TIMER_W)) u_pace (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (frame_cycles),
      .expired  (pace_done)
   );

   rxa_capture #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .in_data   (in_data),
      .full_clr  (full_clr),
      .kind      (kind),
      .rx_data   (rx_data),
      .full_flag (full_flag)
   );

   rxa_status_irq u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .brk_evt   (brk_evt),
      .err_clr   (err_clr),
      .irq_en    (rx_irq_en),
      .ovr_flag  (ovr_flag),
      .frm_flag  (frm_flag),
      .rxi_pulse (rxi_pulse),
      .eri_level (eri_level)
   );
endmodule

// File: rtl/rxa_checker.sv
module rxa_checker #(
   parameter int DATA_W  = 8,
   parameter int TIMER_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rx_en,
   input logic               rx_irq_en,
   input logic [TIMER_W-1:0] frame_cycles,
   input logic               in_valid,
   input logic [DATA_W-1:0]  in_data,
   input logic               in_ready,
   input logic               brk_evt,
   input logic               full_clr,
   input logic               err_clr,
   input logic [DATA_W-1:0]  rx_data,
   input logic               full_flag,
   input logic               ovr_flag,
   input logic               frm_flag,
   input logic               rxi_pulse,
   input logic               eri_level
);
   assert_ready_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> rx_en);

   assert_pace_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && frame_cycles != '0) |=> !in_ready);

   assert_store_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !(full_flag && !full_clr))
      |=> (full_flag && rx_data == $past(in_data)));

   assert_overrun_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && full_flag && !full_clr)
      |=> (ovr_flag && $stable(rx_data)));

   assert_rxi_with_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rxi_pulse |-> full_flag);

   assert_eri_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq_en |=> !eri_level);

   assert_eri_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eri_level && rx_irq_en && !err_clr) |=> eri_level);

   assert_break_frm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> frm_flag);

   assert_clr_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_clr && !(in_valid && in_ready)) |=> !full_flag);
endmodule

bind paced_rx_acceptor rxa_checker #(.DATA_W(DATA_W), .TIMER_W(TIMER_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_en        (rx_en),
   .rx_irq_en    (rx_irq_en),
   .frame_cycles (frame_cycles),
   .in_valid     (in_valid),
   .in_data      (in_data),
   .in_ready     (in_ready),
   .brk_evt      (brk_evt),
   .full_clr     (full_clr),
   .err_clr      (err_clr),
   .rx_data      (rx_data),
   .full_flag    (full_flag),
   .ovr_flag     (ovr_flag),
   .frm_flag     (frm_flag),
   .rxi_pulse    (rxi_pulse),
   .eri_level    (eri_level)
);

// File: tb/sim_paced_rx_acceptor.sv
module sim_paced_rx_acceptor;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int TIMER_W    = 16;
   localparam int NVEC       = 15;
   localparam int PACE       = 5;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               rx_en, rx_irq_en, in_valid, brk_evt, full_clr, err_clr;
   logic [TIMER_W-1:0] frame_cycles;
   logic [DATA_W-1:0]  in_data;
   logic               in_ready;
   logic [DATA_W-1:0]  rx_data;
   logic               full_flag, ovr_flag, frm_flag, rxi_pulse, eri_level;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   paced_rx_acceptor #(.DATA_W(DATA_W), .TIMER_W(TIMER_W)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_irq_en(rx_irq_en),
      .frame_cycles(frame_cycles), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .brk_evt(brk_evt), .full_clr(full_clr),
      .err_clr(err_clr), .rx_data(rx_data), .full_flag(full_flag),
      .ovr_flag(ovr_flag), .frm_flag(frm_flag), .rxi_pulse(rxi_pulse),
      .eri_level(eri_level)
   );

   // Vector layout: en ie valid brk fclr eclr | data | rdy full ovr frm eri rxi | xdata
   localparam logic [27:0] TBL [0:NVEC-1] = '{
      {6'b111000, 8'hA5, 6'b110001, 8'hA5}, // 0  store, pulse          R3 R5
      {6'b110000, 8'h00, 6'b110000, 8'hA5}, // 1  idle
      {6'b111000, 8'h3C, 6'b111010, 8'hA5}, // 2  overrun drop          R4 R6
      {6'b110000, 8'h00, 6'b111010, 8'hA5}, // 3  eri held              R6
      {6'b110001, 8'h00, 6'b110000, 8'hA5}, // 4  err_clr               R9
      {6'b110010, 8'h00, 6'b100000, 8'hA5}, // 5  full_clr              R8
      {6'b111000, 8'h5A, 6'b110001, 8'h5A}, // 6  store
      {6'b111010, 8'hC3, 6'b110001, 8'hC3}, // 7  store with clear      R8
      {6'b110100, 8'h00, 6'b110110, 8'hC3}, // 8  break                 R7 R6
      {6'b100000, 8'h00, 6'b110100, 8'hC3}, // 9  enable dropped        R6
      {6'b100101, 8'h00, 6'b110100, 8'hC3}, // 10 break beats clear     R9
      {6'b100001, 8'h00, 6'b110000, 8'hC3}, // 11 clear frm             R9
      {6'b100010, 8'h00, 6'b100000, 8'hC3}, // 12 clear full
      {6'b011000, 8'h77, 6'b000000, 8'hC3}, // 13 rx disabled           R1
      {6'b101000, 8'h77, 6'b110000, 8'h77}  // 14 store, no pulse       R5
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      in_valid = 1'b0; brk_evt = 1'b0; full_clr = 1'b0; err_clr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle_inputs();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rx_en = 1'b0; rx_irq_en = 1'b0; in_data = '0; frame_cycles = '0;
      do_reset();

      // Reset state
      chk("R10 full",  {31'd0, full_flag}, 32'd0);
      chk("R10 ovr",   {31'd0, ovr_flag},  32'd0);
      chk("R10 frm",   {31'd0, frm_flag},  32'd0);
      chk("R10 rxi",   {31'd0, rxi_pulse}, 32'd0);
      chk("R10 eri",   {31'd0, eri_level}, 32'd0);
      chk("R10 data",  {24'd0, rx_data},   32'd0);
      chk("R1 ready low while disabled", {31'd0, in_ready}, 32'd0);

      // Table with no pacing gap (R2: frame_cycles of zero)
      for (int i = 0; i < NVEC; i++) begin
         logic [27:0] v;
         v = TBL[i];
         {rx_en, rx_irq_en, in_valid, brk_evt, full_clr, err_clr} = v[27:22];
         in_data = v[21:14];
         #1;
         chk($sformatf("R1 R2 vec%0d ready", i), {31'd0, in_ready}, {31'd0, v[13]});
         @(posedge clk);
         @(negedge clk);
         chk($sformatf("R3 R8 vec%0d full", i), {31'd0, full_flag}, {31'd0, v[12]});
         chk($sformatf("R4 R9 vec%0d ovr",  i), {31'd0, ovr_flag},  {31'd0, v[11]});
         chk($sformatf("R7 R9 vec%0d frm",  i), {31'd0, frm_flag},  {31'd0, v[10]});
         chk($sformatf("R6 vec%0d eri",     i), {31'd0, eri_level}, {31'd0, v[9]});
         chk($sformatf("R5 vec%0d rxi",     i), {31'd0, rxi_pulse}, {31'd0, v[8]});
         chk($sformatf("R3 R4 vec%0d data", i), {24'd0, rx_data},   {24'd0, v[7:0]});
         idle_inputs();
      end

      // Pacing gap after reset and after an accepted byte
      frame_cycles = 16'(PACE);
      rx_en = 1'b1; rx_irq_en = 1'b1;
      do_reset();
      #1;
      chk("R1 ready at once after reset", {31'd0, in_ready}, 32'd1);
      in_valid = 1'b1; in_data = 8'h11;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R3 paced byte stored", {24'd0, rx_data}, 32'h11);
      chk("R2 closed after accept", {31'd0, in_ready}, 32'd0);
      repeat (PACE - 1) @(negedge clk);
      chk("R2 still closed at gap end-1", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      chk("R2 reopens after gap", {31'd0, in_ready}, 32'd1);

      // A dropped byte also restarts the gap
      in_valid = 1'b1; in_data = 8'h22;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R4 paced overrun", {31'd0, ovr_flag}, 32'd1);
      chk("R4 data kept", {24'd0, rx_data}, 32'h11);
      chk("R2 closed after dropped byte", {31'd0, in_ready}, 32'd0);
      repeat (PACE) @(negedge clk);
      chk("R2 reopens after dropped byte", {31'd0, in_ready}, 32'd1);

      // Break with receive disabled still flags
      rx_en = 1'b0; err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0; brk_evt = 1'b1;
      @(negedge clk);
      brk_evt = 1'b0;
      chk("R7 break while disabled", {31'd0, frm_flag}, 32'd1);
      chk("R6 eri on break", {31'd0, eri_level}, 32'd1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule